// File: doc/BRIEF.md
# Sequenced-Trigger Capture Buffer

This block is a small on-chip logic-analyzer capture unit. Three single-bit probe inputs each pass through a match unit. Each match unit is set by a two-bit code to look for a 0, a 1, or to always match. Probe 0 and probe 1 feed a two-level trigger sequencer. Probe 2 is the storage qualifier. An 8-bit sample bus is written into a buffer on the rising clock edge, and only on cycles where the qualifier matches. The probe bits themselves are never stored.

The host arms the unit and, at the same moment, gives it a capture depth and a trigger position. The match codes are read live, so they can be changed at run time. Before the trigger, qualified samples go into a circular region that holds the latest "position" samples. After the trigger, qualified samples fill the remaining depth minus position slots, and then the unit reports done.

Readout is by logical index, where index 0 is the oldest stored sample. The unit also reports how many pre-trigger samples it kept, which is the index of the first post-trigger sample.

Top module: `seqtrig_capture`

## Requirements
- R1: Each probe has a two-bit match code. 2'b00 matches a probe value of 0, 2'b01 matches a value of 1, and any code with bit 1 set matches every cycle. Probe 0 uses bits [1:0] of `match_code`, probe 1 uses bits [3:2], and probe 2 uses bits [5:4].
- R2: The trigger fires only when the probe-1 match is seen in a cycle after the cycle that advanced the sequencer, and the sequencer advances on a probe-0 match at level 1. A probe-1 match while the sequencer is still at level 1 has no effect.
- R3: A sample is written only in a cycle where the probe-2 match holds. Unqualified cycles store nothing.
- R4: Before the trigger, the buffer keeps the most recent `cfg_pos` qualified samples and overwrites older ones circularly. `trig_idx` equals the number of pre-trigger samples kept, which is the smaller of the qualified pre-trigger count and `cfg_pos`.
- R5: The qualified sample in the trigger cycle is the first post-trigger sample. `done` rises one cycle after the post-trigger sample count reaches `cfg_depth - cfg_pos`. After that, nothing more is stored until the next arm.
- R6: With `cfg_pos` = 0, every stored sample follows the trigger and `trig_idx` is 0. With `cfg_pos` = `cfg_depth`, `done` rises one cycle after the trigger and no trigger-cycle sample is stored.
- R7: Setting `rd_idx` = k makes `rd_data` show, one clock later, the k-th stored sample in time order. Index 0 is the oldest sample and index `trig_idx` is the first post-trigger sample.
- R8: `arm` returns the sequencer to level 1, empties the buffer, clears `done` from the next cycle on, and latches `cfg_depth` and `cfg_pos`. Without an arm, nothing is stored and `done` stays 0.
- R9: After reset, `done` is 0 and `trig_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | One-cycle pulse that starts a capture and latches the configuration |
| cfg_depth | input | CW (10) | Capture depth in samples, from MIN_DEPTH to DEPTH |
| cfg_pos | input | CW (10) | Trigger position, meaning the number of pre-trigger slots, from 0 to cfg_depth |
| match_code | input | 2*TRIG_PORTS (6) | Per-probe match codes, two bits per probe |
| trig_in | input | TRIG_PORTS (3) | Probe inputs: [0] first level, [1] second level, [2] qualifier |
| sample_data | input | DATA_W (8) | Sampled data bus |
| rd_idx | input | AW (9) | Logical readout index |
| rd_data | output | DATA_W (8) | Sample at `rd_idx`, one cycle later |
| done | output | 1 | Capture complete |
| trig_idx | output | CW (10) | Number of pre-trigger samples kept |

## Verification
The assertions assume the host arms only with a legal configuration: depth between MIN_DEPTH and DEPTH, and position no larger than depth. They also assume `arm` is a pulse that the host does not depend on for data in the same cycle. The random stimulus draws depth only from a legal set and takes position modulo depth plus one, so every arm stays inside these limits. Probe densities are tuned so that each round reaches done in a few hundred cycles. Directed cases cover the position extremes, the case where the probe order is reversed, a re-arm, and activity after done.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_LVL1 = 3'd1,
      SQ_LVL2 = 3'd2,
      SQ_POST = 3'd3,
      SQ_DONE = 3'd4
   } seq_state_e;

   // match code: bit 1 set = always match, else match when probe == bit 0
   localparam int unsigned CODE_W = 2;

endpackage

// File: rtl/seqtrig_match.sv
module seqtrig_match #(
   parameter bit REGISTERED = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] code,
   input  logic       probe,
   output logic       hit
);

   logic hit_raw;

   always_comb hit_raw = code[1] | (probe == code[0]);

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit <= 1'b0;
            else        hit <= hit_raw;
         end
      end else begin : g_comb
         always_comb hit = hit_raw;
      end
   endgenerate

   // R1: a don't-care code always matches
   p_dontcare_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!REGISTERED && code[1]) |-> hit);

endmodule

// File: rtl/seqtrig_seq.sv
module seqtrig_seq
   import seqtrig_pkg::*;
#(
   parameter int unsigned DEPTH     = 512,
   parameter int unsigned MIN_DEPTH = 16,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic [CW-1:0] cfg_depth,
   input  logic [CW-1:0] cfg_pos,
   input  logic          hit_a,
   input  logic          hit_b,
   input  logic          qual,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          done,
   output logic [CW-1:0] pre_cnt,
   output logic [CW-1:0] pre_head,
   output logic [CW-1:0] pos_out
);

   seq_state_e    st_q, st_d;
   logic [CW-1:0] depth_q, pos_q;
   logic [CW-1:0] pre_wptr_q, pre_wptr_d;
   logic [CW-1:0] pre_cnt_q, pre_cnt_d;
   logic [CW-1:0] post_cnt_q, post_cnt_d;
   logic [CW-1:0] need;
   logic [CW-1:0] wr_addr_w;
   logic          trig_fire;

   always_comb begin
      need       = depth_q - pos_q;
      st_d       = st_q;
      pre_wptr_d = pre_wptr_q;
      pre_cnt_d  = pre_cnt_q;
      post_cnt_d = post_cnt_q;
      wr_en      = 1'b0;
      wr_addr_w  = '0;
      trig_fire  = (st_q == SQ_LVL2) && hit_b;
      unique case (st_q)
         SQ_LVL1, SQ_LVL2: begin
            if (!trig_fire) begin
               if (qual && (pos_q != '0)) begin
                  wr_en      = 1'b1;
                  wr_addr_w  = pre_wptr_q;
                  pre_wptr_d = (pre_wptr_q == pos_q - CW'(1)) ? '0 : pre_wptr_q + CW'(1);
                  if (pre_cnt_q != pos_q) pre_cnt_d = pre_cnt_q + CW'(1);
               end
               if ((st_q == SQ_LVL1) && hit_a) st_d = SQ_LVL2;
            end else if (need == '0) begin
               st_d = SQ_DONE;
            end else begin
               st_d = SQ_POST;
               if (qual) begin
                  wr_en      = 1'b1;
                  wr_addr_w  = pos_q;
                  post_cnt_d = CW'(1);
                  if (need == CW'(1)) st_d = SQ_DONE;
               end
            end
         end
         SQ_POST: begin
            if (qual) begin
               wr_en      = 1'b1;
               wr_addr_w  = pos_q + post_cnt_q;
               post_cnt_d = post_cnt_q + CW'(1);
               if (post_cnt_q + CW'(1) == need) st_d = SQ_DONE;
            end
         end
         default: ;
      endcase
      if (arm) begin
         st_d       = SQ_LVL1;
         wr_en      = 1'b0;
         pre_wptr_d = '0;
         pre_cnt_d  = '0;
         post_cnt_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         depth_q    <= CW'(MIN_DEPTH);
         pos_q      <= '0;
         pre_wptr_q <= '0;
         pre_cnt_q  <= '0;
         post_cnt_q <= '0;
      end else begin
         st_q       <= st_d;
         pre_wptr_q <= pre_wptr_d;
         pre_cnt_q  <= pre_cnt_d;
         post_cnt_q <= post_cnt_d;
         if (arm) begin
            depth_q <= cfg_depth;
            pos_q   <= cfg_pos;
         end
      end
   end

   assign wr_addr  = wr_addr_w[AW-1:0];
   assign done     = (st_q == SQ_DONE);
   assign pre_cnt  = pre_cnt_q;
   assign pre_head = pre_wptr_q;
   assign pos_out  = pos_q;

   // R8: host arms only with a legal configuration
   p_cfg_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      arm |-> (cfg_depth >= CW'(MIN_DEPTH) && cfg_depth <= CW'(DEPTH) && cfg_pos <= cfg_depth));
   // R8: arm restarts at level 1 with empty buffer
   p_arm_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (st_q == SQ_LVL1 && !done && pre_cnt_q == '0 && post_cnt_q == '0));
   // R8: nothing is stored while not armed
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_IDLE) |-> !wr_en);
   // R2: level 1 can only stay or step to level 2
   p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_LVL1 && !arm) |=> (st_q == SQ_LVL1 || st_q == SQ_LVL2));
   // R4: pre-trigger count never exceeds the position
   p_pre_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt_q <= pos_q);
   // R4: writes stay inside the capture window
   p_wr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr_w < depth_q));
   // R5: post count bounded by depth minus position
   p_post_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != SQ_IDLE) |-> (post_cnt_q <= need));
   // R5: done holds until the next arm
   p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !arm) |=> done);

endmodule

// File: rtl/seqtrig_store.sv
module seqtrig_store #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DEPTH   = 512,
   parameter bit          RD_PIPE = 1'b0,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_idx,
   input  logic [CW-1:0]     pre_cnt,
   input  logic [CW-1:0]     pre_head,
   input  logic [CW-1:0]     pos,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_q;
   logic [CW-1:0]     k, base, sum, phys;

   // logical index -> physical slot: circular pre region, then linear post region
   always_comb begin
      k    = CW'(rd_idx);
      base = (pre_cnt == pos) ? pre_head : '0;
      sum  = base + k;
      if (k < pre_cnt) phys = (sum >= pos) ? sum - pos : sum;
      else             phys = pos + (k - pre_cnt);
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rd_q <= mem[phys[AW-1:0]];
   end

   generate
      if (RD_PIPE) begin : g_pipe
         logic [DATA_W-1:0] rd_p;
         always_ff @(posedge clk) rd_p <= rd_q;
         assign rd_data = rd_p;
      end else begin : g_direct
         assign rd_data = rd_q;
      end
   endgenerate

   // R7: a pre-trigger index always maps inside the pre region
   p_rd_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (k < pre_cnt) |-> (phys < pos));

endmodule

// File: rtl/seqtrig_capture.sv
module seqtrig_capture #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned DEPTH      = 512,
   parameter int unsigned MIN_DEPTH  = 16,
   parameter int unsigned TRIG_PORTS = 3,
   parameter bit          RD_PIPE    = 1'b0,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = AW + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    arm,
   input  logic [CW-1:0]           cfg_depth,
   input  logic [CW-1:0]           cfg_pos,
   input  logic [2*TRIG_PORTS-1:0] match_code,
   input  logic [TRIG_PORTS-1:0]   trig_in,
   input  logic [DATA_W-1:0]       sample_data,
   input  logic [AW-1:0]           rd_idx,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    done,
   output logic [CW-1:0]           trig_idx
);

   localparam int unsigned P_LVL1 = 0;
   localparam int unsigned P_LVL2 = 1;
   localparam int unsigned P_QUAL = 2;

   generate
      if (TRIG_PORTS != 3) begin : g_bad_ports
         $error("seqtrig_capture: TRIG_PORTS must be 3");
      end
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("seqtrig_capture: DEPTH must be a power of two");
      end
      if (MIN_DEPTH < 1 || MIN_DEPTH > DEPTH) begin : g_bad_min
         $error("seqtrig_capture: MIN_DEPTH out of range");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("seqtrig_capture: DATA_W must be positive");
      end
   endgenerate

   logic [TRIG_PORTS-1:0] hit;
   logic                  wr_en;
   logic [AW-1:0]         wr_addr;
   logic [CW-1:0]         pre_cnt, pre_head, pos_q;

   for (genvar i = 0; i < TRIG_PORTS; i++) begin : g_match
      seqtrig_match #(.REGISTERED(1'b0)) u_match (
         .clk   (clk),
         .rst_n (rst_n),
         .code  (match_code[2*i +: 2]),
         .probe (trig_in[i]),
         .hit   (hit[i])
      );
   end

   seqtrig_seq #(.DEPTH(DEPTH), .MIN_DEPTH(MIN_DEPTH)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm),
      .cfg_depth (cfg_depth),
      .cfg_pos   (cfg_pos),
      .hit_a     (hit[P_LVL1]),
      .hit_b     (hit[P_LVL2]),
      .qual      (hit[P_QUAL]),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .done      (done),
      .pre_cnt   (pre_cnt),
      .pre_head  (pre_head),
      .pos_out   (pos_q)
   );

   seqtrig_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RD_PIPE(RD_PIPE)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (sample_data),
      .rd_idx   (rd_idx),
      .pre_cnt  (pre_cnt),
      .pre_head (pre_head),
      .pos      (pos_q),
      .rd_data  (rd_data)
   );

   assign trig_idx = pre_cnt;

   // R3: a write happens only when the qualifier match holds
   p_qual_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> hit[P_QUAL]);
   // R5: nothing is written once done
   p_no_write_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);

endmodule

// File: tb/seqtrig_capture_tb.sv
module seqtrig_capture_tb;

   localparam int AW = 9;
   localparam int CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm = 1'b0;
   logic [CW-1:0] cfg_depth = 10'd16;
   logic [CW-1:0] cfg_pos = '0;
   logic [5:0]    match_code = 6'b010101;
   logic [2:0]    trig_in = '0;
   logic [7:0]    sample_data = '0;
   logic [AW-1:0] rd_idx = '0;
   logic [7:0]    rd_data;
   logic          done;
   logic [CW-1:0] trig_idx;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   seqtrig_capture u_dut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_depth(cfg_depth), .cfg_pos(cfg_pos),
      .match_code(match_code), .trig_in(trig_in), .sample_data(sample_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .done(done), .trig_idx(trig_idx)
   );

   // reference model state
   int        m_state;   // 0 idle 1 lvl1 2 lvl2 3 post 4 done
   int        m_dep, m_pos;
   logic [7:0] pre_h [8192];
   int        pre_n;
   logic [7:0] post_h [512];
   int        post_n;

   function automatic bit mhit(input logic [1:0] code, input logic b);
      if (code[1]) return 1'b1;
      return b == code[0];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic arm_cap(input int dep, input int pos);
      cfg_depth = CW'(dep);
      cfg_pos = CW'(pos);
      trig_in = '0;
      arm = 1'b1;
      m_state = 1; m_dep = dep; m_pos = pos; pre_n = 0; post_n = 0;
      @(negedge clk);
      arm = 1'b0;
      chk("R8 done cleared by arm", int'(done), 0);
   endtask

   task automatic model_step(input logic p0, input logic p1, input logic p2, input logic [7:0] d);
      bit h0, h1, h2;
      int need;
      h0 = mhit(match_code[1:0], p0);
      h1 = mhit(match_code[3:2], p1);
      h2 = mhit(match_code[5:4], p2);
      need = m_dep - m_pos;
      if (m_state == 1 || m_state == 2) begin
         if (!(m_state == 2 && h1)) begin
            if (h2 && m_pos > 0 && pre_n < 8192) begin pre_h[pre_n] = d; pre_n++; end
            if (m_state == 1 && h0) m_state = 2;
         end else if (need == 0) begin
            m_state = 4;
         end else begin
            m_state = 3;
            if (h2) begin post_h[post_n] = d; post_n++; end
            if (post_n == need) m_state = 4;
         end
      end else if (m_state == 3) begin
         if (h2) begin post_h[post_n] = d; post_n++; end
         if (post_n == need) m_state = 4;
      end
   endtask

   task automatic cyc(input logic p0, input logic p1, input logic p2, input logic [7:0] d);
      trig_in = {p2, p1, p0};
      sample_data = d;
      model_step(p0, p1, p2, d);
      @(negedge clk);
      chk("R5 done timing", int'(done), int'(m_state == 4));
   endtask

   task automatic check_readout();
      int kept;
      kept = (pre_n < m_pos) ? pre_n : m_pos;
      chk("R4 trig_idx", int'(trig_idx), kept);
      for (int k = 0; k < kept + post_n; k++) begin
         int e;
         e = (k < kept) ? int'(pre_h[pre_n - kept + k]) : int'(post_h[k - kept]);
         rd_idx = AW'(k);
         @(negedge clk);
         chk("R7 readout", int'(rd_data), e);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      tests++; fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_state = 0; m_dep = 16; m_pos = 0; pre_n = 0; post_n = 0;
      repeat (3) @(negedge clk);
      chk("R9 done after reset", int'(done), 0);
      chk("R9 trig_idx after reset", int'(trig_idx), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: unarmed unit ignores every probe
      for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 1'b1, 8'(i));

      // R2/R3/R4: probe-1 before probe-0 ignored, gaps unqualified
      match_code = 6'b010101;
      arm_cap(16, 4);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1, 8'(8'h10 + i));
      for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, i[0], 8'(8'h20 + i));
      cyc(1'b1, 1'b0, 1'b1, 8'h30);
      cyc(1'b0, 1'b0, 1'b1, 8'h31);
      chk("R2 no early trigger", int'(done), 0);
      cyc(1'b0, 1'b1, 1'b1, 8'h40);
      for (int i = 0; i < 30 && m_state != 4; i++) cyc(1'b0, 1'b0, i[0], 8'(8'h50 + i));
      chk("R5 done reached", int'(done), 1);
      check_readout();

      // R5: activity after done changes nothing
      for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b1, 8'hEE);
      check_readout();

      // R6: position 0
      arm_cap(16, 0);
      cyc(1'b1, 1'b0, 1'b1, 8'h01);
      for (int i = 0; i < 40 && m_state != 4; i++) cyc(1'b0, i % 5 == 0, 1'b1, 8'(8'h60 + i));
      chk("R6 pos0 trig_idx", int'(trig_idx), 0);
      check_readout();

      // R6: position equals depth
      arm_cap(16, 16);
      for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 1'b1, 8'(8'h70 + i));
      cyc(1'b1, 1'b0, 1'b1, 8'h90);
      cyc(1'b0, 1'b1, 1'b1, 8'h91);
      chk("R6 pos=depth done at trigger", int'(done), 1);
      check_readout();

      // R1: match-0 on probe 0, don't-care qualifier
      match_code = 6'b100100;
      arm_cap(32, 8);
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b0, 8'(8'hA0 + i));
      chk("R1 match-1 probe0 not level advance", m_state, 1);
      cyc(1'b0, 1'b0, 1'b0, 8'hB0);
      for (int i = 0; i < 60 && m_state != 4; i++) cyc(1'b1, i % 3 == 0, 1'b0, 8'(8'hC0 + i));
      chk("R1 done with don't-care qualifier", int'(done), 1);
      check_readout();

      // random rounds
      for (int r = 0; r < 14; r++) begin
         int dsel, dep, pos;
         dsel = int'($urandom % 5);
         dep = (dsel == 0) ? 16 : (dsel == 1) ? 37 : (dsel == 2) ? 64 : (dsel == 3) ? 200 : 512;
         pos = int'($urandom % (dep + 1));
         match_code[1:0] = ($urandom % 3 == 0) ? 2'b00 : 2'b01;
         match_code[3:2] = ($urandom % 4 == 0) ? 2'b10 : 2'b01;
         match_code[5:4] = ($urandom % 4 == 0) ? 2'b11 : 2'b01;
         arm_cap(dep, pos);
         for (int i = 0; i < 6000 && m_state != 4; i++)
            cyc($urandom % 8 == 0, $urandom % 4 == 0, $urandom % 2 == 0, 8'($urandom));
         chk("R5 random capture completes", int'(done), 1);
         if (m_state == 4) check_readout();
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule